// File: doc/BRIEF.md
# SIMD Instruction Fault Classifier

This block decides, for one packed floating-point SIMD instruction at a time, whether the instruction must fault and with which fault class. The issue logic presents a snapshot of the machine state on one strobe cycle. That snapshot holds the operating mode, the control bits that govern SIMD use, the feature-present bit, whether the source operand comes from memory, the effective address with its stack-segment and canonical flags, and whether the arithmetic produced an unmasked numeric exception. One cycle later the block returns a registered verdict.

The verdict is a fault-valid flag and a three-bit fault class. For the two address-fault classes it also returns a zero error code, flagged as present. The checks are taken in a fixed priority: feature enables first, then the device-not-available check, then the address faults, and last the routing of the numeric exception. Page faults, descriptor loading and the arithmetic itself are handled elsewhere.

Top module: `simd_fault_check`

## Requirements
- R1: While `rst_n` is low, and after it until the first strobe, `out_valid`, `fault_valid`, `fault_type`, `err_code_valid` and `err_code` are all zero.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` on the following cycle. Strobes on consecutive cycles each get their own result. `fault_valid` is high only with `out_valid`, and `fault_type` is encoded as 0 none, 1 invalid-opcode, 2 device-not-available, 3 general-protection, 4 stack, 5 SIMD-numeric.
- R3: If `ctl_emul` is 1, `ctl_fxsave_en` is 0 or `feat_present` is 0, the result is type 1, whatever the other inputs are.
- R4: With no R3 condition present, `ctl_task_sw` = 1 gives type 2, whatever the address and numeric inputs are.
- R5: A memory operand whose `eff_addr[3:0]` is not zero gives type 3, in every mode and whatever `stack_seg` is.
- R6: In real mode (`op_mode` 0) and virtual-8086 mode (`op_mode` 1), a memory operand whose last byte (`eff_addr`+15) lies above 0xFFFF gives type 3. `eff_addr` = 0xFFF0 does not fault.
- R7: In 64-bit mode (`op_mode` 3), a memory operand with `addr_canonical` = 0 gives type 4 when `stack_seg` = 1 and type 3 otherwise. This takes precedence over the alignment check. Outside 64-bit mode, `addr_canonical` has no effect.
- R8: If no fault above applies, `numeric_exc` = 1 gives type 5 when `ctl_simd_exc_en` = 1 and type 1 when it is 0.
- R9: When `mem_op` = 0, the values of `eff_addr`, `stack_seg` and `addr_canonical` have no effect on the result.
- R10: `err_code_valid` is 1 exactly when the result type is 3 or 4, and `err_code` is always zero.
- R11: Protected and compatibility mode share `op_mode` 2. In that mode an aligned memory operand above 0xFFFF with `addr_canonical` = 0 does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: the snapshot below is to be classified |
| op_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| ctl_emul | input | 1 | Control bit: SIMD instructions are emulated |
| ctl_task_sw | input | 1 | Control bit: SIMD state is not available (task switched) |
| ctl_fxsave_en | input | 1 | Control bit: OS supports SIMD state save |
| ctl_simd_exc_en | input | 1 | Control bit: OS handles SIMD numeric exceptions |
| feat_present | input | 1 | Instruction-set feature bit from identification |
| mem_op | input | 1 | Source operand is in memory |
| stack_seg | input | 1 | Memory access uses the stack segment |
| eff_addr | input | AW (64) | Effective address of the memory operand |
| addr_canonical | input | 1 | Address is in canonical form |
| numeric_exc | input | 1 | Arithmetic raised an unmasked numeric exception |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| fault_valid | output | 1 | A fault is raised |
| fault_type | output | 3 | Encoded fault class |
| err_code_valid | output | 1 | The fault class pushes an error code |
| err_code | output | ERRW (16) | Error code, always zero |

## Verification
The assertions assume that every input is held stable and well defined on each strobe cycle, and that the control bits are treated as part of the snapshot, so that a rule can be stated against the cycle before each result. They also assume that reset is held long enough for `in_valid` to be low on the cycle before release. The stimulus holds reset low over several edges with the strobe low, and changes every input only on falling edges. It keeps `addr_canonical` at 1 whenever the intent is to exercise a check other than the canonical one, so each directed case triggers only the rules it names unless it is a deliberate priority case.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;
   typedef enum logic [2:0] {
      FLT_NONE = 3'd0,
      FLT_UD   = 3'd1,
      FLT_NM   = 3'd2,
      FLT_GP   = 3'd3,
      FLT_SS   = 3'd4,
      FLT_XM   = 3'd5
   } flt_e;

   typedef enum logic [1:0] {
      MD_REAL   = 2'd0,
      MD_V86    = 2'd1,
      MD_LEGACY = 2'd2,
      MD_LONG   = 2'd3
   } mode_e;
endpackage

// File: rtl/sfc_enable_check.sv
module sfc_enable_check (
   input  logic emul,
   input  logic task_sw,
   input  logic fxsave_en,
   input  logic feat,
   output logic ud_hit,
   output logic nm_hit
);
   // Feature and OS-support gate: any missing enable is an invalid opcode.
   assign ud_hit = emul | ~fxsave_en | ~feat;
   // Device-not-available only matters when the opcode itself is legal.
   assign nm_hit = task_sw & ~ud_hit;
endmodule

// File: rtl/sfc_addr_check.sv
module sfc_addr_check
   import simd_fault_pkg::*;
#(
   parameter int AW          = 64,
   parameter int ALIGN_BYTES = 16,
   parameter int OPND_BYTES  = 16,
   parameter int SEG_LIMIT   = 32'h0000_FFFF
) (
   input  mode_e          mode,
   input  logic           mem_op,
   input  logic           stk,
   input  logic [AW-1:0]  addr,
   input  logic           canon,
   output logic           gp_hit,
   output logic           ss_hit
);
   localparam int ALIGN_BITS = $clog2(ALIGN_BYTES);
   localparam logic [AW:0] LAST_OFS = (AW+1)'(OPND_BYTES - 1);
   localparam logic [AW:0] LIMIT_V  = (AW+1)'(SEG_LIMIT);

   logic misalign;
   logic [AW:0] last_byte;
   logic over_limit;
   logic low_mode;
   logic noncanon;

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign misalign = 1'b0;
      end else begin : g_align
         assign misalign = |addr[ALIGN_BITS-1:0];
      end
   endgenerate

   assign last_byte  = {1'b0, addr} + LAST_OFS;
   assign over_limit = last_byte > LIMIT_V;
   assign low_mode   = (mode == MD_REAL) || (mode == MD_V86);
   assign noncanon   = (mode == MD_LONG) && !canon;

   assign ss_hit = mem_op & noncanon & stk;
   assign gp_hit = mem_op & ~(noncanon & stk) &
                   ((noncanon & ~stk) | misalign | (low_mode & over_limit));
endmodule

// File: rtl/sfc_prio.sv
module sfc_prio
   import simd_fault_pkg::*;
(
   input  logic ud_hit,
   input  logic nm_hit,
   input  logic gp_hit,
   input  logic ss_hit,
   input  logic num_exc,
   input  logic exc_en,
   output flt_e flt
);
   always_comb begin
      if (ud_hit)       flt = FLT_UD;
      else if (nm_hit)  flt = FLT_NM;
      else if (ss_hit)  flt = FLT_SS;
      else if (gp_hit)  flt = FLT_GP;
      else if (num_exc) flt = exc_en ? FLT_XM : FLT_UD;
      else              flt = FLT_NONE;
   end
endmodule

// File: rtl/simd_fault_check.sv
module simd_fault_check
   import simd_fault_pkg::*;
#(
   parameter int AW          = 64,
   parameter int ERRW        = 16,
   parameter int ALIGN_BYTES = 16,
   parameter int OPND_BYTES  = 16,
   parameter int SEG_LIMIT   = 32'h0000_FFFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [1:0]      op_mode,
   input  logic            ctl_emul,
   input  logic            ctl_task_sw,
   input  logic            ctl_fxsave_en,
   input  logic            ctl_simd_exc_en,
   input  logic            feat_present,
   input  logic            mem_op,
   input  logic            stack_seg,
   input  logic [AW-1:0]   eff_addr,
   input  logic            addr_canonical,
   input  logic            numeric_exc,
   output logic            out_valid,
   output logic            fault_valid,
   output logic [2:0]      fault_type,
   output logic            err_code_valid,
   output logic [ERRW-1:0] err_code
);
   generate
      if (AW < 17) begin : g_bad_aw
         $error("AW must cover the 16-bit segment limit");
      end
      if (ERRW < 1) begin : g_bad_errw
         $error("ERRW must be at least 1");
      end
      if ((ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
         $error("ALIGN_BYTES must be a power of two");
      end
      if (OPND_BYTES < 1) begin : g_bad_opnd
         $error("OPND_BYTES must be positive");
      end
   endgenerate

   logic ud_hit, nm_hit, gp_hit, ss_hit;
   flt_e flt_d;

   sfc_enable_check u_en (
      .emul      (ctl_emul),
      .task_sw   (ctl_task_sw),
      .fxsave_en (ctl_fxsave_en),
      .feat      (feat_present),
      .ud_hit    (ud_hit),
      .nm_hit    (nm_hit)
   );

   sfc_addr_check #(
      .AW          (AW),
      .ALIGN_BYTES (ALIGN_BYTES),
      .OPND_BYTES  (OPND_BYTES),
      .SEG_LIMIT   (SEG_LIMIT)
   ) u_addr (
      .mode   (mode_e'(op_mode)),
      .mem_op (mem_op),
      .stk    (stack_seg),
      .addr   (eff_addr),
      .canon  (addr_canonical),
      .gp_hit (gp_hit),
      .ss_hit (ss_hit)
   );

   sfc_prio u_prio (
      .ud_hit  (ud_hit),
      .nm_hit  (nm_hit),
      .gp_hit  (gp_hit),
      .ss_hit  (ss_hit),
      .num_exc (numeric_exc),
      .exc_en  (ctl_simd_exc_en),
      .flt     (flt_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         fault_valid    <= 1'b0;
         fault_type     <= FLT_NONE;
         err_code_valid <= 1'b0;
         err_code       <= '0;
      end else begin
         out_valid      <= in_valid;
         fault_valid    <= in_valid && (flt_d != FLT_NONE);
         fault_type     <= in_valid ? flt_d : FLT_NONE;
         err_code_valid <= in_valid && ((flt_d == FLT_GP) || (flt_d == FLT_SS));
         err_code       <= '0;
      end
   end
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
   parameter int AW   = 64,
   parameter int ERRW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            ctl_emul,
   input logic            ctl_task_sw,
   input logic            ctl_fxsave_en,
   input logic            ctl_simd_exc_en,
   input logic            feat_present,
   input logic            mem_op,
   input logic [AW-1:0]   eff_addr,
   input logic            numeric_exc,
   input logic            out_valid,
   input logic            fault_valid,
   input logic [2:0]      fault_type,
   input logic            err_code_valid,
   input logic [ERRW-1:0] err_code
);
   logic en_ok;
   assign en_ok = !ctl_emul && ctl_fxsave_en && feat_present;

   // R2
   out_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R2
   fault_needs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> out_valid);

   // R3
   ud_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !en_ok) |=> (fault_type == 3'd1));

   // R4
   nm_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && en_ok && ctl_task_sw) |=> (fault_type == 3'd2));

   // R5
   misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && en_ok && !ctl_task_sw && mem_op && (eff_addr[3:0] != 4'd0))
      |=> ((fault_type == 3'd3) || (fault_type == 3'd4)));

   // R8
   xm_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && en_ok && !ctl_task_sw && !mem_op && numeric_exc)
      |=> (fault_type == ($past(ctl_simd_exc_en) ? 3'd5 : 3'd1)));

   // R9
   regsrc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && en_ok && !ctl_task_sw && !mem_op && !numeric_exc)
      |=> !fault_valid);

   // R10
   errcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_code_valid |-> (((fault_type == 3'd3) || (fault_type == 3'd4)) && (err_code == '0)));
endmodule

bind simd_fault_check sfc_chk #(.AW(AW), .ERRW(ERRW)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .in_valid        (in_valid),
   .ctl_emul        (ctl_emul),
   .ctl_task_sw     (ctl_task_sw),
   .ctl_fxsave_en   (ctl_fxsave_en),
   .ctl_simd_exc_en (ctl_simd_exc_en),
   .feat_present    (feat_present),
   .mem_op          (mem_op),
   .eff_addr        (eff_addr),
   .numeric_exc     (numeric_exc),
   .out_valid       (out_valid),
   .fault_valid     (fault_valid),
   .fault_type      (fault_type),
   .err_code_valid  (err_code_valid),
   .err_code        (err_code)
);

// File: tb/simd_fault_check_tb.sv
module simd_fault_check_tb;
   localparam int AW   = 64;
   localparam int ERRW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [1:0] op_mode = 2'd2;
   logic ctl_emul = 1'b0, ctl_task_sw = 1'b0, ctl_fxsave_en = 1'b1;
   logic ctl_simd_exc_en = 1'b1, feat_present = 1'b1;
   logic mem_op = 1'b0, stack_seg = 1'b0, addr_canonical = 1'b1, numeric_exc = 1'b0;
   logic [AW-1:0] eff_addr = '0;
   logic out_valid, fault_valid, err_code_valid;
   logic [2:0] fault_type;
   logic [ERRW-1:0] err_code;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   simd_fault_check #(.AW(AW), .ERRW(ERRW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_mode(op_mode),
      .ctl_emul(ctl_emul), .ctl_task_sw(ctl_task_sw), .ctl_fxsave_en(ctl_fxsave_en),
      .ctl_simd_exc_en(ctl_simd_exc_en), .feat_present(feat_present),
      .mem_op(mem_op), .stack_seg(stack_seg), .eff_addr(eff_addr),
      .addr_canonical(addr_canonical), .numeric_exc(numeric_exc),
      .out_valid(out_valid), .fault_valid(fault_valid), .fault_type(fault_type),
      .err_code_valid(err_code_valid), .err_code(err_code)
   );

   // Expected class taken from the requirement list, in priority order.
   function automatic int model(input logic [1:0] md, input logic em, input logic ts,
                                input logic fx, input logic xe, input logic ft,
                                input logic mem, input logic stk, input logic [AW-1:0] a,
                                input logic cn, input logic nx);
      if (em || !fx || !ft) return 1;
      if (ts) return 2;
      if (mem) begin
         if (md == 2'd3 && !cn) return stk ? 4 : 3;
         if (a[3:0] != 4'd0) return 3;
         if (md < 2'd2 && a > 64'hFFF0) return 3;
      end
      if (nx) return xe ? 5 : 1;
      return 0;
   endfunction

   task automatic send(input logic [1:0] md, input logic em, input logic ts,
                       input logic fx, input logic xe, input logic ft,
                       input logic mem, input logic stk, input logic [AW-1:0] a,
                       input logic cn, input logic nx, input string tag);
      @(negedge clk);
      in_valid = 1'b1; op_mode = md; ctl_emul = em; ctl_task_sw = ts;
      ctl_fxsave_en = fx; ctl_simd_exc_en = xe; feat_present = ft;
      mem_op = mem; stack_seg = stk; eff_addr = a; addr_canonical = cn; numeric_exc = nx;
      exp_q.push_back(model(md, em, ts, fx, xe, ft, mem, stk, a, cn, nx));
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      eff_addr = 64'hDEAD_BEEF_0000_0007;
   endtask

   // Monitor: scoreboard comparison on falling edges.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
            end else begin
               int    e;
               string t;
               logic  ev;
               e  = exp_q.pop_front();
               t  = tag_q.pop_front();
               ev = (e == 3) || (e == 4);
               checks++;
               if (fault_type != 3'(e) || fault_valid != (e != 0) ||
                   err_code_valid != ev || err_code != '0) begin
                  errors++;
                  $display("FAIL %s (R10 err code) actual type=%0d fv=%0b ecv=%0b ec=%0h expected type=%0d fv=%0b ecv=%0b ec=0",
                           t, fault_type, fault_valid, err_code_valid, err_code, e, e != 0, ev);
               end
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      checks++;
      // R1 reset state
      if (out_valid || fault_valid || fault_type != 3'd0 || err_code_valid || err_code != '0) begin
         errors++;
         $display("FAIL R1 reset outputs: actual ov=%0b fv=%0b t=%0d expected all zero",
                  out_valid, fault_valid, fault_type);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid || fault_type != 3'd0) begin
         errors++;
         $display("FAIL R1 after release: actual ov=%0b t=%0d expected 0 0", out_valid, fault_type);
      end
      // args: mode em ts fx xe feat mem stk addr canon nexc
      send(2'd2, 0,0,1,1,1, 0,0, 64'h0, 1, 0, "R2 clean");
      send(2'd2, 1,1,1,1,1, 1,0, 64'h3, 1, 1, "R3 emul");
      send(2'd3, 0,1,0,1,1, 0,0, 64'h0, 1, 0, "R3 fxsave off");
      send(2'd0, 0,0,1,1,0, 0,0, 64'h0, 1, 1, "R3 feature off");
      idle();
      send(2'd2, 0,1,1,1,1, 1,1, 64'h1008, 1, 1, "R4 task switched");
      send(2'd2, 0,0,1,1,1, 1,0, 64'h1008, 1, 0, "R5 misaligned");
      send(2'd2, 0,0,1,1,1, 1,1, 64'h1004, 1, 0, "R5 misaligned stack");
      send(2'd3, 0,0,1,1,1, 1,0, 64'h2001, 1, 0, "R5 misaligned long");
      idle();
      send(2'd0, 0,0,1,1,1, 1,0, 64'hFFF0, 1, 0, "R6 real at edge");
      send(2'd0, 0,0,1,1,1, 1,0, 64'h10000, 1, 0, "R6 real beyond");
      send(2'd1, 0,0,1,1,1, 1,1, 64'hFFF0, 1, 0, "R6 v86 at edge");
      send(2'd1, 0,0,1,1,1, 1,0, 64'h20000, 1, 0, "R6 v86 beyond");
      idle();
      send(2'd2, 0,0,1,1,1, 1,0, 64'h10000, 0, 0, "R11 protected high");
      send(2'd3, 0,0,1,1,1, 1,1, 64'h8000_0000_0000_0010, 0, 0, "R7 noncanon stack");
      send(2'd3, 0,0,1,1,1, 1,0, 64'h8000_0000_0000_0010, 0, 0, "R7 noncanon data");
      send(2'd3, 0,0,1,1,1, 1,1, 64'h8000_0000_0000_0003, 0, 0, "R7 noncanon over misalign");
      send(2'd1, 0,0,1,1,1, 1,1, 64'h100, 0, 0, "R7 flag ignored v86");
      idle();
      send(2'd2, 0,0,1,1,1, 0,0, 64'h0, 1, 1, "R8 route xm");
      send(2'd2, 0,0,1,0,1, 0,0, 64'h0, 1, 1, "R8 route ud");
      send(2'd2, 0,0,1,1,1, 1,0, 64'h0C, 1, 1, "R8 address first");
      send(2'd3, 0,0,1,1,1, 1,0, 64'h40, 1, 1, "R8 aligned mem xm");
      idle();
      send(2'd3, 0,0,1,1,1, 0,1, 64'h8000_0000_0000_0003, 0, 0, "R9 reg src long");
      send(2'd0, 0,0,1,1,1, 0,0, 64'h3_FFFF, 1, 0, "R9 reg src real");
      idle();
      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2 missing results: actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule